// File: doc/BRIEF.md
# Serial-Port Converter Front End

This block is the digital side of a 10-bit converter that a host reaches over a four-wire serial link: an active-low select, a host-driven shift clock, a serial channel address going in, and a result line coming out. All three host pins run asynchronously to the block. Each is synchronised into a faster system clock and turned into single-cycle edge events there. While the host clocks a new channel number in on the rising shift edges, the block sends the result of the previous conversion out on the falling edges. A frame is 10 to 16 shift clocks long.

The block marks the analog sampling window for an external analog model and presents the selected channel to it. After the tenth falling edge it hands off to a conversion sequencer. Here that sequencer is a fixed-latency stand-in that captures a supplied 10-bit value. The end-of-conversion flag is low while the sequencer is busy. The next frame then shifts out the captured value. Sources 0 to 10 are external inputs, 11 to 13 are internal self-test levels, and 14 and 15 are reserved.

Top module: `serial_adc_front`

## Requirements
- R1: After reset the result line is not driven, `sdo_oe` is 0, `eoc` is 1, `sample_en` is 0, `chan_sel` is 0 and the stored result is 0.
- R2: While `cs_n` is high the result line is high-impedance and `sdo_oe` is 0. After a falling edge of `cs_n`, `sdo` drives bit 9 (the MSB) of the previously stored result.
- R3: The channel number is taken MSB first from `addr_in` on the first four rising edges of `sclk`. `chan_sel` shows the full 4-bit value after the fourth rising edge.
- R4: Once four address bits have been taken, `addr_in` has no effect on `chan_sel` for the rest of the frame.
- R5: The k-th falling edge of `sclk` (k = 1..9) puts result bit 9-k on `sdo`, so the LSB appears after the ninth falling edge.
- R6: From the tenth falling edge onward `sdo` is driven to 0 for every further clock of the frame.
- R7: `sample_en` is high from the fourth falling edge until the tenth falling edge and is low at all other times. A rise of `cs_n` also clears it.
- R8: The tenth falling edge drops `eoc` to 0 and starts a conversion. `CONV_CYCLES` system cycles later `conv_in` is stored as the new result and `eoc` returns to 1.
- R9: If `cs_n` rises before the tenth falling edge, no conversion starts, `eoc` stays 1 and the stored result is kept.
- R10: `chan_ok` is 1 exactly when `chan_sel` is below 14. Codes 14 and 15 are reserved.
- R11: Each falling edge of `cs_n` restarts the address and bit counters, so a frame that follows an aborted one takes its address from bit 3 again and shifts out from the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host shift clock, asynchronous |
| addr_in | input | 1 | Serial channel address from the host |
| conv_in | input | 10 | Value the conversion stand-in captures |
| sdo | output | 1 | Tri-state serial result line |
| sdo_oe | output | 1 | High while `sdo` is driven |
| eoc | output | 1 | End of conversion, low while converting |
| sample_en | output | 1 | Sampling window for the analog model |
| chan_sel | output | 4 | Selected source for the analog model |
| chan_ok | output | 1 | Selected source is not a reserved code |

## Verification
The assertions assume a well-behaved host. It keeps each pin level steady for several system cycles, it never moves `sclk` and `cs_n` in the same window, and it does not start a new frame while a conversion is still running. The stimulus holds every pin for at least four system cycles and uses eight-cycle shift half-periods. After each frame it waits well beyond `CONV_CYCLES` before selecting the block again. The sweep covers all sixteen address codes at every frame length from 10 to 16, together with frames aborted at 1, 3, 4, 6 and 9 clocks.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int SAMPLE_OPEN_EDGE = 4;
  localparam int FRAME_END_EDGE   = 10;
  localparam int EDGE_CNT_W       = 5;

  function automatic logic [EDGE_CNT_W-1:0] sat_inc(input logic [EDGE_CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic src_legal(input logic [7:0] code, input int num_src);
    return int'(code) < num_src;
  endfunction

  function automatic logic out_bit(input logic [15:0] word, input int width,
                                   input logic [EDGE_CNT_W-1:0] falls);
    if (int'(falls) >= width) return 1'b0;
    return word[width - 1 - int'(falls)];
  endfunction
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
        s3 <= RST_VAL[g];
      end else begin
        s1 <= pin[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[g]  = s2;
    assign rise[g] = s2 & ~s3;
    assign fall[g] = ~s2 & s3;
  end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall,
  input  logic                  cs_rise,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  addr_bit,
  input  logic [RES_W-1:0]      prev_result,
  output logic                  sdo_bit,
  output logic                  sdo_oe,
  output logic                  sample_en,
  output logic [ADDR_W-1:0]     chan_sel,
  output logic                  ld_chan,
  output logic                  start_ev,
  output logic [EDGE_CNT_W-1:0] fall_cnt
);
  localparam int RC_W = $clog2(ADDR_W + 1);

  logic              active;
  logic [RC_W-1:0]   rise_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [RES_W-1:0]  out_sh;
  logic              open_ev;
  logic              take_bit;

  assign take_bit = active && sck_rise && (int'(rise_cnt) < ADDR_W);
  assign ld_chan  = take_bit && (int'(rise_cnt) == ADDR_W - 1);
  assign open_ev  = active && sck_fall && (int'(fall_cnt) == SAMPLE_OPEN_EDGE - 1);
  assign start_ev = active && sck_fall && (int'(fall_cnt) == FRAME_END_EDGE - 1);
  assign sdo_bit  = out_sh[RES_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sdo_oe    <= 1'b0;
      rise_cnt  <= '0;
      fall_cnt  <= '0;
      addr_sh   <= '0;
      out_sh    <= '0;
      chan_sel  <= '0;
      sample_en <= 1'b0;
    end else if (cs_fall) begin
      active    <= 1'b1;
      sdo_oe    <= 1'b1;
      rise_cnt  <= '0;
      fall_cnt  <= '0;
      addr_sh   <= '0;
      out_sh    <= prev_result;
      sample_en <= 1'b0;
    end else if (cs_rise) begin
      active    <= 1'b0;
      sdo_oe    <= 1'b0;
      sample_en <= 1'b0;
    end else begin
      if (take_bit) begin
        addr_sh  <= {addr_sh[ADDR_W-2:0], addr_bit};
        rise_cnt <= rise_cnt + 1'b1;
      end
      if (ld_chan) chan_sel <= {addr_sh[ADDR_W-2:0], addr_bit};
      if (active && sck_fall) begin
        fall_cnt <= sat_inc(fall_cnt);
        out_sh   <= {out_sh[RES_W-2:0], 1'b0};
      end
      if (open_ev)       sample_en <= 1'b1;
      else if (start_ev) sample_en <= 1'b0;
    end
  end
endmodule

// File: rtl/sadc_conv.sv
module sadc_conv #(
  parameter int RES_W       = 10,
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ev,
  input  logic [RES_W-1:0] conv_in,
  output logic [RES_W-1:0] result,
  output logic             eoc,
  output logic             done_ev
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  assign done_ev = busy && (int'(cnt) == CONV_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      result <= '0;
      eoc    <= 1'b1;
    end else if (start_ev && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
      eoc  <= 1'b0;
    end else if (done_ev) begin
      busy   <= 1'b0;
      result <= conv_in;
      eoc    <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_adc_front.sv
module serial_adc_front
  import sadc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int NUM_SRC     = 14,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              addr_in,
  input  logic [RES_W-1:0]  conv_in,
  output wire               sdo,
  output logic              sdo_oe,
  output logic              eoc,
  output logic              sample_en,
  output logic [ADDR_W-1:0] chan_sel,
  output logic              chan_ok
);
  logic [2:0]            pin_lvl, pin_rise, pin_fall;
  logic                  cs_fall_ev, cs_rise_ev, sck_rise_ev, sck_fall_ev;
  logic                  sdo_bit, ld_chan, start_ev, done_ev;
  logic [RES_W-1:0]      result;
  logic [EDGE_CNT_W-1:0] fall_cnt;

  sadc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({cs_n, sclk, addr_in}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign cs_fall_ev  = pin_fall[2];
  assign cs_rise_ev  = pin_rise[2];
  assign sck_rise_ev = pin_rise[1];
  assign sck_fall_ev = pin_fall[1];

  sadc_frame #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall_ev), .cs_rise(cs_rise_ev),
    .sck_rise(sck_rise_ev), .sck_fall(sck_fall_ev), .addr_bit(pin_lvl[0]),
    .prev_result(result), .sdo_bit(sdo_bit), .sdo_oe(sdo_oe),
    .sample_en(sample_en), .chan_sel(chan_sel), .ld_chan(ld_chan),
    .start_ev(start_ev), .fall_cnt(fall_cnt)
  );

  sadc_conv #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .conv_in(conv_in),
    .result(result), .eoc(eoc), .done_ev(done_ev)
  );

  assign chan_ok = src_legal(8'(chan_sel), NUM_SRC);
  assign sdo     = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/serial_adc_front_chk.sv
module serial_adc_front_chk
  import sadc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_fall_ev,
  input logic                  cs_rise_ev,
  input logic                  start_ev,
  input logic                  done_ev,
  input logic                  ld_chan,
  input logic                  sdo_oe,
  input logic                  sdo_bit,
  input logic                  eoc,
  input logic                  sample_en,
  input logic [ADDR_W-1:0]     chan_sel,
  input logic [EDGE_CNT_W-1:0] fall_cnt
);
  AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_fall_ev |=> sdo_oe); // R2
  AST_IDLE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_rise_ev |=> (!sdo_oe && !sample_en)); // R7
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n) !ld_chan |=> $stable(chan_sel)); // R4
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (sdo_oe && int'(fall_cnt) >= FRAME_END_EDGE) |-> !sdo_bit); // R6
  AST_EOC_DROP: assert property (@(posedge clk) disable iff (!rst_n) start_ev |=> !eoc); // R8
  AST_EOC_RISE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(eoc) |-> $past(done_ev)); // R9
endmodule

bind serial_adc_front serial_adc_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall_ev(cs_fall_ev), .cs_rise_ev(cs_rise_ev),
  .start_ev(start_ev), .done_ev(done_ev), .ld_chan(ld_chan), .sdo_oe(sdo_oe),
  .sdo_bit(sdo_bit), .eoc(eoc), .sample_en(sample_en), .chan_sel(chan_sel),
  .fall_cnt(fall_cnt)
);

// File: tb/serial_adc_front_bench.sv
`timescale 1ns/1ps
module serial_adc_front_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       addr_in = 1'b0;
  logic [9:0] conv_in = '0;
  wire        sdo;
  logic       sdo_oe, eoc, sample_en, chan_ok;
  logic [3:0] chan_sel;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [9:0] prev = '0;
  logic [3:0] exp_chan = '0;

  always #2 clk = ~clk;

  serial_adc_front u_serial_adc_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .addr_in(addr_in),
    .conv_in(conv_in), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc),
    .sample_en(sample_en), .chan_sel(chan_sel), .chan_ok(chan_ok)
  );

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frame(input logic [3:0] a, input int n, input logic [9:0] newv);
    conv_in = newv;
    cs_n = 1'b0;
    step(8);
    chk("R2 oe on select", int'(sdo_oe), 1);
    chk("R2 R11 msb", int'(sdo), int'(prev[9]));
    for (int i = 1; i <= n; i++) begin
      addr_in = (i <= 4) ? a[4-i] : (a[0] ^ i[0]);
      step(4);
      sclk = 1'b1;
      step(8);
      if (i == 4) begin
        exp_chan = a;
        chk("R3 channel", int'(chan_sel), int'(a));
        chk("R10 legal", int'(chan_ok), int'(a < 4'd14));
      end else if (i > 4) begin
        chk("R4 address ignored", int'(chan_sel), int'(a));
      end
      sclk = 1'b0;
      step(8);
      chk(i <= 9 ? "R5 bit" : "R6 zero", int'(sdo), (i <= 9) ? int'(prev[9-i]) : 0);
      chk("R7 window", int'(sample_en), int'(i >= 4 && i < 10));
      if (i == 10) chk("R8 eoc low", int'(eoc), 0);
    end
    cs_n = 1'b1;
    step(8);
    chk("R2 released", int'(sdo_oe), 0);
    chk("R7 closed", int'(sample_en), 0);
    step(40);
    chk(n >= 10 ? "R8 eoc high" : "R9 no conversion", int'(eoc), 1);
    chk("R4 channel kept", int'(chan_sel), int'(exp_chan));
    if (n >= 10) prev = newv;
  endtask

  initial begin
    step(3);
    chk("R1 oe", int'(sdo_oe), 0);
    chk("R1 eoc", int'(eoc), 1);
    rst_n = 1'b1;
    step(5);
    chk("R1 oe", int'(sdo_oe), 0);
    chk("R1 eoc", int'(eoc), 1);
    chk("R1 window", int'(sample_en), 0);
    chk("R1 chan", int'(chan_sel), 0);
    chk("R10 reset legal", int'(chan_ok), 1);
    for (int a = 0; a < 16; a++) begin
      for (int n = 10; n <= 16; n++) begin
        frame(4'(a), n, 10'((a * 73 + n * 29 + 5) & 10'h3ff));
      end
    end
    foreach (prev[k]) begin end
    for (int j = 0; j < 5; j++) begin
      int na;
      na = (j == 0) ? 1 : (j == 1) ? 3 : (j == 2) ? 4 : (j == 3) ? 6 : 9;
      frame(4'(j * 3 + 1), na, 10'h155);
      frame(4'(15 - j), 10, 10'(j * 201 + 7));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule